// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of three per-axis acceleration magnitudes and reports short shocks ("taps"). A tap is an excursion above a programmable threshold, on any axis the user has enabled, that drops back below the threshold within a programmable maximum duration. When double-tap detection is on, a first tap is followed by a quiet latency period. A window then opens in which a second tap may start. The block emits a one-cycle pulse for a single tap and a one-cycle pulse for a double tap. It also keeps a one-hot record of the axis that crossed first at the most recent tap start.

Samples arrive with a strobe. Time is measured with a separate prescaled tick input, so a system can feed it a real-time base while a testbench compresses time. Duration limits count ticks. Latency and window limits count in units of `LW_RATIO` ticks (default 2), so the latency and window step is twice the duration step. Magnitudes are unsigned and already scaled to the threshold units.

Top module: `tap_detect`

## Requirements
- R1: A sample counts as above threshold when at least one axis whose bit is set in `axis_en_i` (bit 0 = x, bit 1 = y, bit 2 = z) has a magnitude strictly greater than `thresh_i`. Axes whose enable bit is clear never contribute.
- R2: An excursion qualifies as a tap when it ends with a below-threshold sample before `dur_i` ticks have elapsed since its first above sample. With a tick on every sample, 1 to `dur_i` consecutive above samples qualify, and one more above sample cancels the tap.
- R3: When double-tap detection is inactive, `single_o` is high in the cycle directly after the clock edge that takes the first below-threshold sample ending a qualifying tap, provided `sgl_en_i` is set.
- R4: Latency lasts `latency_i*LW_RATIO` ticks from the end of the first tap. The window then lasts `window_i*LW_RATIO` ticks. With a tick on every sample and G below samples between the two taps, a double tap needs G in the range from latency ticks + 1 to latency ticks + window ticks. If the window closes with no second tap, the first tap is reported as a single tap.
- R5: The second tap has to start inside the window but may end after it. If the second tap lasts longer than the duration limit, the double tap is rejected.
- R6: If the signal is above threshold in the tick in which latency expires, the double tap is rejected.
- R7: With `suppress_i` set, any above-threshold sample during latency rejects the double tap. With it clear, such samples are ignored.
- R8: While double-tap detection is active, the single-tap report is held until the double tap is confirmed or rejected. A rejection or window timeout gives `single_o` alone. A confirmation gives `double_o` and, if `sgl_en_i` is set, `single_o` in the same cycle.
- R9: A `dur_i` of zero disables all tap detection. A zero `latency_i`, zero `window_i` or clear `dbl_en_i` makes double-tap detection inactive, so every tap is reported as a single tap at once.
- R10: `first_axis_o` is loaded at each tap start with the one-hot code of the lowest-numbered axis above threshold (x before y before z). At all other times it keeps its value and is never cleared, except by reset.
- R11: Synchronous active-high reset clears `single_o`, `double_o` and `first_axis_o` and returns the detector to idle.
- R12: `single_o` and `double_o` are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | A new magnitude sample is present |
| tick_i | input | 1 | Prescaled time base, one duration unit |
| mag_x_i | input | MW | Unsigned x magnitude |
| mag_y_i | input | MW | Unsigned y magnitude |
| mag_z_i | input | MW | Unsigned z magnitude |
| thresh_i | input | MW | Tap threshold |
| dur_i | input | TW | Maximum tap length in ticks; 0 disables taps |
| latency_i | input | TW | Quiet time after the first tap, in LW_RATIO-tick units |
| window_i | input | TW | Second-tap window, in LW_RATIO-tick units |
| axis_en_i | input | 3 | Per-axis participation, bit 0 = x |
| suppress_i | input | 1 | Above-threshold sample during latency rejects double tap |
| sgl_en_i | input | 1 | Report single taps |
| dbl_en_i | input | 1 | Detect double taps |
| single_o | output | 1 | Single-tap pulse |
| double_o | output | 1 | Double-tap pulse |
| first_axis_o | output | 3 | One-hot axis of the latest tap start |

## Verification
Confirming a double tap is the one moment when both event outputs rise together. The deferred single report and the double report are produced by the same decision. Every stimulus row counts the cycles in which `single_o` and `double_o` are high together, and this count must equal the expected number of double taps when single reporting is on, or zero when it is off. Rows built to reject or time out the second tap, such as a window that has just closed, an over-long second tap or a suppressed latency, must show `single_o` alone, and must never show the two pulses together.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int NAX = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAP1,
    ST_LAT,
    ST_WIN,
    ST_TAP2,
    ST_HOLD
  } tap_state_e;
endpackage

// File: rtl/tap_axis_cmp.sv
module tap_axis_cmp #(
  parameter int NAX = 3,
  parameter int MW  = 8
) (
  input  logic [NAX*MW-1:0] mag_flat,
  input  logic [MW-1:0]     thr,
  input  logic [NAX-1:0]    en,
  output logic [NAX-1:0]    hit,
  output logic [NAX-1:0]    first,
  output logic              any
);
  for (genvar gi = 0; gi < NAX; gi++) begin : g_axis
    assign hit[gi] = en[gi] && (mag_flat[gi*MW +: MW] > thr);
  end

  // isolate the lowest set bit: axis 0 wins over 1, 1 over 2
  assign first = hit & (~hit + NAX'(1));
  assign any   = |hit;
endmodule

// File: rtl/tap_interval_cnt.sv
module tap_interval_cnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] lim,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (adv && (cnt_q != {CW{1'b1}})) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = adv && (((CW+1)'(cnt_q) + (CW+1)'(1)) >= (CW+1)'(lim));
endmodule

// File: rtl/tap_seq_fsm.sv
module tap_seq_fsm
  import tap_pkg::*;
#(
  parameter int TW       = 8,
  parameter int LW_RATIO = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_vld,
  input  logic           tick,
  input  logic           hit_any,
  input  logic [NAX-1:0] first_hit,
  input  logic [TW-1:0]  dur,
  input  logic [TW-1:0]  lat,
  input  logic [TW-1:0]  win,
  input  logic           suppress,
  input  logic           sgl_en,
  input  logic           dbl_en,
  output logic           single_o,
  output logic           double_o,
  output logic [NAX-1:0] rec_o
);
  localparam int CW = TW + $clog2(LW_RATIO) + 1;

  tap_state_e    state_q, nxt;
  logic          lvl_q;
  logic          fire_s, fire_d, rec_ld;
  logic          expire;
  logic [CW-1:0] lim;
  logic          dbl_act, tap_on, above_now, low_smp, high_smp;

  assign dbl_act   = dbl_en && (lat != '0) && (win != '0);
  assign tap_on    = (dur != '0) && (sgl_en || dbl_act);
  assign low_smp   = smp_vld && !hit_any;
  assign high_smp  = smp_vld && hit_any;
  assign above_now = smp_vld ? hit_any : lvl_q;

  always_comb begin
    case (state_q)
      ST_LAT:  lim = CW'(lat) * CW'(LW_RATIO);
      ST_WIN:  lim = CW'(win) * CW'(LW_RATIO);
      default: lim = CW'(dur);
    endcase
  end

  tap_interval_cnt #(.CW(CW)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (nxt != state_q),
    .adv    (tick),
    .lim    (lim),
    .expire (expire)
  );

  always_comb begin
    nxt    = state_q;
    fire_s = 1'b0;
    fire_d = 1'b0;
    rec_ld = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tap_on && high_smp) begin
          nxt    = ST_TAP1;
          rec_ld = 1'b1;
        end
      end
      ST_TAP1: begin
        if (!tap_on) nxt = ST_IDLE;
        else if (low_smp) begin
          if (dbl_act) nxt = ST_LAT;
          else begin
            fire_s = sgl_en;
            nxt    = ST_IDLE;
          end
        end else if (expire) nxt = ST_HOLD;
      end
      ST_LAT: begin
        if (!tap_on || !dbl_act) begin
          fire_s = sgl_en && tap_on;
          nxt    = ST_IDLE;
        end else if (suppress && high_smp) begin
          fire_s = sgl_en;
          nxt    = ST_HOLD;
        end else if (expire) begin
          if (above_now) begin
            fire_s = sgl_en;
            nxt    = ST_HOLD;
          end else nxt = ST_WIN;
        end
      end
      ST_WIN: begin
        if (!tap_on || !dbl_act) begin
          fire_s = sgl_en && tap_on;
          nxt    = ST_IDLE;
        end else if (high_smp) begin
          nxt    = ST_TAP2;
          rec_ld = 1'b1;
        end else if (expire) begin
          fire_s = sgl_en;
          nxt    = ST_IDLE;
        end
      end
      ST_TAP2: begin
        if (!tap_on || !dbl_act) begin
          fire_s = sgl_en && tap_on;
          nxt    = ST_IDLE;
        end else if (low_smp) begin
          fire_s = sgl_en;
          fire_d = 1'b1;
          nxt    = ST_IDLE;
        end else if (expire) begin
          fire_s = sgl_en;
          nxt    = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (low_smp || !tap_on) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      lvl_q    <= 1'b0;
      single_o <= 1'b0;
      double_o <= 1'b0;
      rec_o    <= '0;
    end else begin
      state_q  <= nxt;
      single_o <= fire_s;
      double_o <= fire_d;
      if (smp_vld) lvl_q <= hit_any;
      if (rec_ld) rec_o <= first_hit;
    end
  end
endmodule

// File: rtl/tap_detect.sv
module tap_detect
  import tap_pkg::*;
#(
  parameter int MW       = 8,
  parameter int TW       = 8,
  parameter int LW_RATIO = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld_i,
  input  logic          tick_i,
  input  logic [MW-1:0] mag_x_i,
  input  logic [MW-1:0] mag_y_i,
  input  logic [MW-1:0] mag_z_i,
  input  logic [MW-1:0] thresh_i,
  input  logic [TW-1:0] dur_i,
  input  logic [TW-1:0] latency_i,
  input  logic [TW-1:0] window_i,
  input  logic [2:0]    axis_en_i,
  input  logic          suppress_i,
  input  logic          sgl_en_i,
  input  logic          dbl_en_i,
  output logic          single_o,
  output logic          double_o,
  output logic [2:0]    first_axis_o
);
  logic [NAX-1:0] hit, first_hit;
  logic           hit_any;

  tap_axis_cmp #(.NAX(NAX), .MW(MW)) cmp_i (
    .mag_flat ({mag_z_i, mag_y_i, mag_x_i}),
    .thr      (thresh_i),
    .en       (axis_en_i),
    .hit      (hit),
    .first    (first_hit),
    .any      (hit_any)
  );

  tap_seq_fsm #(.TW(TW), .LW_RATIO(LW_RATIO)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld_i),
    .tick      (tick_i),
    .hit_any   (hit_any),
    .first_hit (first_hit),
    .dur       (dur_i),
    .lat       (latency_i),
    .win       (window_i),
    .suppress  (suppress_i),
    .sgl_en    (sgl_en_i),
    .dbl_en    (dbl_en_i),
    .single_o  (single_o),
    .double_o  (double_o),
    .rec_o     (first_axis_o)
  );
endmodule

// File: rtl/tap_detect_chk.sv
module tap_detect_chk #(
  parameter int MW = 8,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_vld_i,
  input logic [TW-1:0] dur_i,
  input logic [TW-1:0] latency_i,
  input logic [TW-1:0] window_i,
  input logic          sgl_en_i,
  input logic          dbl_en_i,
  input logic          single_o,
  input logic          double_o,
  input logic [2:0]    first_axis_o
);
  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    single_o |=> !single_o);
  // R12
  double_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    double_o |=> !double_o);
  // R9
  dur_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (single_o || double_o) |-> ($past(dur_i) != '0));
  // R9
  dbl_gate_chk: assert property (@(posedge clk) disable iff (rst)
    double_o |-> ($past(dbl_en_i) && ($past(latency_i) != '0) && ($past(window_i) != '0)));
  // R8
  coincide_chk: assert property (@(posedge clk) disable iff (rst)
    double_o |-> (single_o == $past(sgl_en_i)));
  // R10
  rec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(first_axis_o));
  // R10
  rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(smp_vld_i) |-> $stable(first_axis_o));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!single_o && !double_o && (first_axis_o == 3'b000)));
endmodule

bind tap_detect tap_detect_chk #(.MW(MW), .TW(TW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .smp_vld_i    (smp_vld_i),
  .dur_i        (dur_i),
  .latency_i    (latency_i),
  .window_i     (window_i),
  .sgl_en_i     (sgl_en_i),
  .dbl_en_i     (dbl_en_i),
  .single_o     (single_o),
  .double_o     (double_o),
  .first_axis_o (first_axis_o)
);

// File: tb/tap_detect_tb_top.sv
module tap_detect_tb_top;
  localparam int MW = 8;
  localparam int TW = 8;
  localparam logic [MW-1:0] HI = 8'd150;
  localparam logic [MW-1:0] LO = 8'd20;
  localparam int NROWS = 16;

  typedef struct packed {
    logic [3:0] rq;
    logic [7:0] dur, lat, win;
    logic       sup, sgl, dbl;
    logic [2:0] aen;
    logic [1:0] ax1;
    logic [7:0] l1, g;
    logic [1:0] ax2;
    logic [7:0] l2;
    logic [3:0] es, ed;
    logic [2:0] eax;
  } row_t;

  function automatic row_t mk(int rq, int dur, int lat, int win, int sup, int sgl, int dbl,
                              int aen, int ax1, int l1, int g, int ax2, int l2,
                              int es, int ed, int eax);
    row_t r;
    r.rq = 4'(rq); r.dur = 8'(dur); r.lat = 8'(lat); r.win = 8'(win);
    r.sup = 1'(sup); r.sgl = 1'(sgl); r.dbl = 1'(dbl); r.aen = 3'(aen);
    r.ax1 = 2'(ax1); r.l1 = 8'(l1); r.g = 8'(g); r.ax2 = 2'(ax2); r.l2 = 8'(l2);
    r.es = 4'(es); r.ed = 4'(ed); r.eax = 3'(eax);
    return r;
  endfunction

  // dur lat win sup sgl dbl aen ax1 l1 g ax2 l2 | singles doubles axis
  localparam row_t TBL [NROWS] = '{
    mk(2, 4,3,5, 0,1,0, 7, 2,3, 0, 0,0, 1,0, 3'b100), // R2 short tap, z recorded
    mk(2, 4,3,5, 0,1,0, 7, 0,4, 0, 0,0, 1,0, 3'b001), // R2 length equal to limit
    mk(2, 4,3,5, 0,1,0, 7, 1,5, 0, 0,0, 0,0, 3'b010), // R2 too long
    mk(4, 4,3,5, 0,1,1, 7, 0,2, 8, 1,2, 1,1, 3'b010), // R4 double inside window
    mk(4, 4,3,5, 0,1,1, 7, 2,2, 7, 0,2, 1,1, 3'b001), // R4 first window tick
    mk(5, 4,3,5, 0,1,1, 7, 1,2,16, 0,3, 1,1, 3'b001), // R5 starts last tick, ends late
    mk(4, 4,3,5, 0,1,1, 7, 0,2,17, 2,2, 2,0, 3'b100), // R4 window missed
    mk(6, 4,3,5, 0,1,1, 7, 0,2, 6, 1,2, 1,0, 3'b001), // R6 above when window opens
    mk(7, 4,3,5, 1,1,1, 7, 0,2, 3, 1,2, 1,0, 3'b001), // R7 suppressed
    mk(7, 4,3,5, 0,1,1, 7, 0,2, 3, 1,1, 1,0, 3'b001), // R7 latency blip ignored
    mk(5, 4,3,5, 0,1,1, 7, 0,2, 8, 1,5, 1,0, 3'b010), // R5 second tap too long
    mk(8, 4,3,5, 0,0,1, 7, 0,2, 8, 2,2, 0,1, 3'b100), // R8 double only
    mk(9, 0,3,5, 0,1,1, 7, 0,2, 8, 1,2, 0,0, 3'b000), // R9 zero duration
    mk(9, 4,0,5, 0,1,1, 7, 0,2, 8, 1,2, 2,0, 3'b010), // R9 zero latency
    mk(9, 4,3,0, 0,1,1, 7, 0,2, 8, 1,2, 2,0, 3'b010), // R9 zero window
    mk(1, 4,3,5, 0,1,1, 5, 1,2, 0, 0,0, 0,0, 3'b000)  // R1 masked axis
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_vld_i = 1'b0, tick_i = 1'b0;
  logic [MW-1:0] mag_x_i = '0, mag_y_i = '0, mag_z_i = '0;
  logic [MW-1:0] thresh_i = 8'd100;
  logic [TW-1:0] dur_i = '0, latency_i = '0, window_i = '0;
  logic [2:0]    axis_en_i = '0;
  logic          suppress_i = 1'b0, sgl_en_i = 1'b0, dbl_en_i = 1'b0;
  logic          single_o, double_o;
  logic [2:0]    first_axis_o;

  int checks = 0, errors = 0;
  int s_cnt, d_cnt, b_cnt;

  always #5 clk = ~clk;

  tap_detect #(.MW(MW), .TW(TW), .LW_RATIO(2)) dut_i (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .tick_i(tick_i),
    .mag_x_i(mag_x_i), .mag_y_i(mag_y_i), .mag_z_i(mag_z_i),
    .thresh_i(thresh_i), .dur_i(dur_i), .latency_i(latency_i), .window_i(window_i),
    .axis_en_i(axis_en_i), .suppress_i(suppress_i), .sgl_en_i(sgl_en_i), .dbl_en_i(dbl_en_i),
    .single_o(single_o), .double_o(double_o), .first_axis_o(first_axis_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] hi);
    smp_vld_i = 1'b1;
    tick_i    = 1'b1;
    mag_x_i   = hi[0] ? HI : LO;
    mag_y_i   = hi[1] ? HI : LO;
    mag_z_i   = hi[2] ? HI : LO;
    @(posedge clk);
    #1;
    if (single_o) s_cnt++;
    if (double_o) d_cnt++;
    if (single_o && double_o) b_cnt++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3'b000);
    step(3'b000);
    rst = 1'b0;
    s_cnt = 0; d_cnt = 0; b_cnt = 0;
  endtask

  task automatic cfg(input row_t r);
    dur_i = r.dur; latency_i = r.lat; window_i = r.win;
    suppress_i = r.sup; sgl_en_i = r.sgl; dbl_en_i = r.dbl; axis_en_i = r.aen;
  endtask

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    cfg(TBL[0]);
    do_reset();
    chk("R11 single after reset", int'(single_o), 0);
    chk("R11 double after reset", int'(double_o), 0);
    chk("R11 axis after reset", int'(first_axis_o), 0);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      row_t r = TBL[i];
      cfg(r);
      do_reset();
      repeat (5) step(3'b000);
      repeat (int'(r.l1)) step(3'(3'b001 << r.ax1));
      repeat (int'(r.g)) step(3'b000);
      repeat (int'(r.l2)) step(3'(3'b001 << r.ax2));
      repeat (40) step(3'b000);
      chk($sformatf("R%0d row %0d single count", r.rq, i), s_cnt, int'(r.es));
      chk($sformatf("R%0d row %0d double count", r.rq, i), d_cnt, int'(r.ed));
      chk($sformatf("R10 row %0d first axis", i), int'(first_axis_o), int'(r.eax));
      // R8 coincidence of single and double on confirmation
      chk($sformatf("R8 row %0d coincident pulses", i), b_cnt, r.sgl ? int'(r.ed) : 0);
    end

    // R3 single-only timing, R12 pulse width
    cfg(TBL[0]);
    do_reset();
    step(3'b000);
    step(3'b001);
    step(3'b001);
    chk("R3 no report while above", int'(single_o), 0);
    step(3'b000);
    chk("R3 report right after falling sample", int'(single_o), 1);
    step(3'b000);
    chk("R12 single lasts one cycle", int'(single_o), 0);

    // R10 priority among simultaneous axes with x masked; R1 mask
    axis_en_i = 3'b110;
    do_reset();
    step(3'b000);
    step(3'b111);
    step(3'b000);
    chk("R10 lowest enabled axis wins", int'(first_axis_o), 3'b010);
    chk("R1 masked x does not block tap", int'(single_o), 1);

    // R1 threshold is strict: magnitude equal to threshold is not above
    axis_en_i = 3'b111;
    do_reset();
    smp_vld_i = 1'b1; tick_i = 1'b1;
    mag_x_i = thresh_i; mag_y_i = LO; mag_z_i = LO;
    @(posedge clk); #1;
    step(3'b000);
    repeat (3) step(3'b000);
    chk("R1 equal magnitude not a crossing", s_cnt, 0);
    chk("R1 equal magnitude leaves record", int'(first_axis_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule